// File: doc/BRIEF.md
# Pre-Reset Handshake Sequencer

This block sits between the reset sources of a processor subsystem and its domain reset outputs. When a warm or cold reset is requested, it does not apply the reset at once. It first raises a request to every peer whose handshake is enabled. The peers include the trace unit, the fabric bridges and the external-memory front end. It then waits until each enabled peer has acknowledged, or until a programmable cycle budget runs out. Only after that does it pulse the warm or cold reset output for a fixed number of cycles.

Whether the external-memory I/O bank and its controller are reset with the rest depends on the memory flush handshake. If that handshake is enabled and the memory front end acknowledged it, the memory side is left alone and its contents survive the reset. If the handshake is disabled, or its acknowledge never came, the memory reset is asserted as well. This clears outstanding traffic at the cost of retraining and lost contents. A timed-out handshake never blocks the reset. The handshakes that timed out are recorded in a status output, which is kept until the next sequence starts. No cache flush is part of the sequence.

Top module: `rst_hs_seq`

## Requirements
- R1: A warm sequence starts when `sw_warm` or `wdog_warm` is high at a clock edge in idle. A cold sequence starts when `sw_cold`, `wdog_cold` or a low level on `cold_pin_n` is seen at that edge. Cold wins if both kinds arrive at the same edge. Exactly one of `warm_rst`/`cold_rst` pulses, matching the sequence kind.
- R2: A write with `cfg_sel`=0 loads the handshake enable mask from `cfg_wdata[6:0]`. A write with `cfg_sel`=1 loads the timeout count from `cfg_wdata`. After reset the mask is 0 and the timeout is 0x2800. Writes made while a sequence is in progress are ignored.
- R3: From the cycle after the trigger edge, `hs_req` equals the enable mask, bit for bit. Bit 0 is trace stall, bit 1 is fabric handshake, bits 2 to 5 are the four bridge flushes, and bit 6 is the memory flush. The requests hold until the reset phase begins, and then all of them drop to 0.
- R4: Acknowledges are remembered once seen. The handshake phase ends at the first edge where every enabled bit has been acknowledged. With no acknowledges and timeout T, the handshake phase lasts T+1 cycles, so the reset output rises T+2 cycles after the trigger is applied (T=0 gives 2).
- R5: The reset output stays high for RST_CYC (default 4) cycles, and then the block returns to idle. Triggers that arrive during a sequence are ignored.
- R6: `mem_rst` is high during the reset phase unless bit 6 is enabled and was acknowledged. In that case it stays low. It is never high outside the reset phase.
- R7: When the handshake phase ends, `hs_tmo` captures the enabled bits that were never acknowledged. It is cleared when the next sequence starts.
- R8: A handshake with its enable bit clear is treated as complete. With an all-zero mask no request is raised, and the reset output rises 2 cycles after the trigger.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer itself |
| sw_warm | input | 1 | Software/mailbox warm reset request |
| sw_cold | input | 1 | Software/mailbox cold reset request |
| wdog_warm | input | 1 | Watchdog warm reset request |
| wdog_cold | input | 1 | Watchdog cold reset request |
| cold_pin_n | input | 1 | Dedicated cold reset pin, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: enable mask, 1: timeout count |
| cfg_wdata | input | 16 | Configuration write data |
| hs_ack | input | 7 | Handshake acknowledges from the peers |
| hs_req | output | 7 | Handshake requests to the peers |
| hs_tmo | output | 7 | Handshakes that timed out in the last sequence |
| warm_rst | output | 1 | Warm domain reset |
| cold_rst | output | 1 | Cold domain reset |
| mem_rst | output | 1 | Reset of the memory I/O bank and controller |

## Verification
The requests appear one cycle after the trigger edge. The reset outputs and `hs_tmo` change one cycle after the edge that ends the handshake phase. `mem_rst` follows the same timing as the reset outputs. A behavioural model in the bench advances on the same rising edge as the design, and all outputs are compared against it at each falling edge, where nothing is in transition. Directed checks also count the falling edges from the trigger to the rising reset output and compare that count with T+2, or with 2 when no handshake is enabled or the timeout is 0. This pins down the latency for several timeouts, including the 0x2800 reset value.

// File: rtl/rst_hs_seq.sv
module rst_hs_seq #(
  parameter int NHS         = 7,
  parameter int TW          = 16,
  parameter int RST_CYC     = 4,
  parameter int TMO_DEFAULT = 'h2800
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_warm,
  input  logic           sw_cold,
  input  logic           wdog_warm,
  input  logic           wdog_cold,
  input  logic           cold_pin_n,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [TW-1:0]  cfg_wdata,
  input  logic [NHS-1:0] hs_ack,
  output logic [NHS-1:0] hs_req,
  output logic [NHS-1:0] hs_tmo,
  output logic           warm_rst,
  output logic           cold_rst,
  output logic           mem_rst
);
  localparam int MEM = NHS - 1;
  localparam int RCW = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_HS, S_RST} state_t;

  state_t           state;
  logic [NHS-1:0]   en_q, acked, tmo_q;
  logic [TW-1:0]    to_q, cnt;
  logic [RCW-1:0]   rcnt;
  logic             is_cold, mem_keep;

  wire cold_trig = sw_cold | wdog_cold | ~cold_pin_n;
  wire warm_trig = sw_warm | wdog_warm;
  wire [NHS-1:0] acked_nx = acked | hs_ack;
  wire hs_done = &(acked_nx | ~en_q);
  wire in_rst = (state == S_RST);

  assign hs_req   = (state == S_HS) ? en_q : '0;
  assign hs_tmo   = tmo_q;
  assign warm_rst = in_rst & ~is_cold;
  assign cold_rst = in_rst & is_cold;
  assign mem_rst  = in_rst & ~mem_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      en_q     <= '0;
      to_q     <= TW'(TMO_DEFAULT);
      cnt      <= '0;
      acked    <= '0;
      tmo_q    <= '0;
      rcnt     <= '0;
      is_cold  <= 1'b0;
      mem_keep <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cold_trig | warm_trig) begin
            state   <= S_HS;
            cnt     <= to_q;
            is_cold <= cold_trig;
            acked   <= '0;
            tmo_q   <= '0;
          end else if (cfg_we) begin
            if (cfg_sel) to_q <= cfg_wdata;
            else         en_q <= cfg_wdata[NHS-1:0];
          end
        end
        S_HS: begin
          acked <= acked_nx;
          if (hs_done || cnt == '0) begin
            state    <= S_RST;
            tmo_q    <= en_q & ~acked_nx;
            mem_keep <= en_q[MEM] & acked_nx[MEM];
            rcnt     <= RCW'(RST_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (rcnt == '0) state <= S_IDLE;
          else            rcnt  <= rcnt - 1'b1;
        end
      endcase
    end
  end

  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warm_rst, cold_rst}));

  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(en_q) && $stable(to_q)));

  assert_req_drop_at_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|hs_req) |-> (warm_rst || cold_rst));

  assert_mem_in_reset_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rst |-> (warm_rst || cold_rst));

  assert_mem_keep_needs_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_rst || cold_rst) && !mem_rst) |-> en_q[MEM]);
endmodule

// File: tb/test_rst_hs_seq.sv
module test_rst_hs_seq;
  localparam int NHS = 7;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst_n, sw_warm, sw_cold, wdog_warm, wdog_cold, cold_pin_n;
  logic cfg_we, cfg_sel;
  logic [15:0] cfg_wdata;
  logic [NHS-1:0] hs_ack, hs_req, hs_tmo;
  logic warm_rst, cold_rst, mem_rst;

  int vectors = 0, fails = 0, wd = 0;

  rst_hs_seq i_rst_hs_seq (
    .clk(clk), .rst_n(rst_n), .sw_warm(sw_warm), .sw_cold(sw_cold),
    .wdog_warm(wdog_warm), .wdog_cold(wdog_cold), .cold_pin_n(cold_pin_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hs_ack(hs_ack),
    .hs_req(hs_req), .hs_tmo(hs_tmo), .warm_rst(warm_rst), .cold_rst(cold_rst),
    .mem_rst(mem_rst)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int m_phase, m_cnt, m_rc;
  bit m_cold, m_keep;
  logic [NHS-1:0] m_en, m_acked, m_tmo;
  int m_to;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_en = 0; m_to = 'h2800; m_tmo = 0; m_keep = 0; m_cold = 0;
      m_acked = 0; m_cnt = 0; m_rc = 0;
    end else if (m_phase == 0) begin
      if (sw_cold || wdog_cold || !cold_pin_n || sw_warm || wdog_warm) begin
        m_phase = 1; m_cnt = m_to; m_acked = 0; m_tmo = 0;
        m_cold = sw_cold || wdog_cold || !cold_pin_n;
      end else if (cfg_we) begin
        if (cfg_sel) m_to = int'(cfg_wdata);
        else m_en = cfg_wdata[NHS-1:0];
      end
    end else if (m_phase == 1) begin
      m_acked = m_acked | hs_ack;
      if ((m_en & ~m_acked) == 0 || m_cnt == 0) begin
        m_phase = 2; m_tmo = m_en & ~m_acked;
        m_keep = m_en[NHS-1] && m_acked[NHS-1]; m_rc = RST_CYC - 1;
      end else m_cnt--;
    end else begin
      if (m_rc == 0) m_phase = 0; else m_rc--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 hs_req", 32'(hs_req), 32'((m_phase == 1) ? m_en : 7'h0));
    chk("R1/R5 warm_rst", 32'(warm_rst), 32'(m_phase == 2 && !m_cold));
    chk("R1/R5 cold_rst", 32'(cold_rst), 32'(m_phase == 2 && m_cold));
    chk("R6 mem_rst", 32'(mem_rst), 32'(m_phase == 2 && !m_keep));
    chk("R7 hs_tmo", 32'(hs_tmo), 32'(m_tmo));
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic cfg(input bit sel, input logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // trig = {pin, wdog_cold, sw_cold, wdog_warm, sw_warm}
  task automatic fire(input logic [4:0] trig, output int n);
    {wdog_cold, sw_cold, wdog_warm, sw_warm} = trig[3:0];
    cold_pin_n = ~trig[4];
    @(negedge clk);
    {wdog_cold, sw_cold, wdog_warm, sw_warm} = 4'b0;
    cold_pin_n = 1;
    n = 1;
    while (!(warm_rst || cold_rst)) begin @(negedge clk); n++; end
  endtask

  task automatic settle();
    while (warm_rst || cold_rst) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 0; sw_warm = 0; sw_cold = 0; wdog_warm = 0; wdog_cold = 0;
    cold_pin_n = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; hs_ack = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 32'({hs_req, hs_tmo, warm_rst, cold_rst, mem_rst}), 0);
    rst_n = 1;
    @(negedge clk);

    // full handshake acknowledged, memory preserved
    cfg(0, 16'h7f); cfg(1, 16'd20);
    sw_warm = 1; @(negedge clk); sw_warm = 0;
    chk("R3 requests raised", 32'(hs_req), 32'h7f);
    repeat (2) @(negedge clk);
    hs_ack = 7'h3f; repeat (2) @(negedge clk); hs_ack = 7'h7f;
    while (!warm_rst) @(negedge clk);
    chk("R6 memory kept on ack", 32'(mem_rst), 0);
    hs_ack = 0; settle();
    chk("R7 no timeouts", 32'(hs_tmo), 0);

    // no acks: timeout path
    fire(5'b00010, n);
    chk("R4 timeout latency T=20", 32'(n), 32'd22);
    chk("R6 memory reset after timeout", 32'(mem_rst), 1);
    settle();
    chk("R7 all timed out", 32'(hs_tmo), 32'h7f);

    // memory flush disabled, everything acked immediately
    cfg(0, 16'h3f); hs_ack = 7'h7f;
    fire(5'b00100, n);
    chk("R1 cold kind", 32'({warm_rst, cold_rst}), 32'b01);
    chk("R6 memory reset when flush off", 32'(mem_rst), 1);
    chk("R4 early finish on acks", 32'(n), 32'd2);
    settle(); hs_ack = 0;

    // nothing enabled
    cfg(0, 16'h0);
    fire(5'b00001, n);
    chk("R8 empty mask latency", 32'(n), 32'd2);
    settle();
    chk("R8 no timeouts on empty mask", 32'(hs_tmo), 0);

    // pin and warm together: cold wins
    fire(5'b10001, n);
    chk("R1 cold priority", 32'({warm_rst, cold_rst}), 32'b01);
    settle();

    // config and triggers ignored while busy
    cfg(0, 16'h55); cfg(1, 16'd50);
    sw_warm = 1; @(negedge clk); sw_warm = 0;
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h0; sw_cold = 1; @(negedge clk);
    cfg_sel = 1; cfg_wdata = 16'd1; @(negedge clk);
    cfg_we = 0; sw_cold = 0;
    n = 3;
    while (!(warm_rst || cold_rst)) begin @(negedge clk); n++; end
    chk("R2 timeout write ignored while busy", 32'(n), 32'd52);
    chk("R5 trigger ignored while busy", 32'({warm_rst, cold_rst}), 32'b10);
    n = 0;
    while (warm_rst) begin @(negedge clk); n++; end
    chk("R5 reset width", 32'(n), RST_CYC);
    @(negedge clk);
    wdog_warm = 1; @(negedge clk); wdog_warm = 0;
    chk("R2 mask write ignored while busy", 32'(hs_req), 32'h55);
    while (!warm_rst) @(negedge clk);
    settle();

    // zero timeout
    cfg(1, 16'd0);
    fire(5'b01000, n);
    chk("R4 zero timeout latency", 32'(n), 32'd2);
    settle();

    // reset values: default timeout
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R9 outputs after reset", 32'({hs_req, hs_tmo, warm_rst, cold_rst, mem_rst}), 0);
    cfg(0, 16'h40);
    fire(5'b00001, n);
    chk("R2 default timeout 0x2800", 32'(n), 32'h2800 + 2);
    settle();
    chk("R7 memory flush timed out", 32'(hs_tmo), 32'h40);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule